// File: doc/BRIEF.md
# Vertical SEC-DED Memory Scrubber

This engine guards a region of 32-bit words in an ordinary synchronous RAM with a single-error-correcting, double-error-detecting Hamming code that runs *down* the memory rather than across each word. A codeword is one bit position (a slice) taken from 64 protected words, with 8 check bits. All 32 slices of a block are handled together, one word per cycle. The code is systematic: the protected words are never rewritten by encoding, and the check words sit in their own area just after the protected region.

Software issues an encode command after loading or changing the protected content. The engine then reads every data word and writes the check words. It issues a scrub command periodically. The scrub re-reads data and check words and forms 32 syndromes at once. It repairs every slice that holds a single error with a read-modify-write, and it counts and reports slices that hold two errors. The region is organised in groups of four blocks whose words are interleaved in the address space, so a burst of upsets in neighbouring words spreads over separate codewords.

Top module: `vslice_scrubber`

## Requirements
- R1: An encode writes eight check words per block. Data row r (0..63) has Hamming position p(r), the (r+1)-th integer of 3, 5, 6, 7, 9, ... that is not a power of two. For j in 0..6, bit i of check word j is the XOR of bit i of every row whose p(r) has bit j set. Bit i of check word 7 is the XOR of bit i of all 64 data words and of check words 0..6.
- R2: An encode writes no address outside the check area.
- R3: Word offset a from the base belongs to group a/256. Within that group it is row (a mod 256)/4 of block 4*(a/256)+(a mod 4). The check words of block b are at base + 256*groups + 8*b + j, for j = 0..7.
- R4: A scrub of an intact region writes nothing, and both event counters stay unchanged.
- R5: A scrub fixes a single flipped data bit and adds one to the corrected-event counter.
- R6: Two flipped bits in one word lie in separate slices, and a scrub repairs both. Flips in adjacent words fall in separate blocks and are repaired too. Each repaired bit adds one to the corrected counter.
- R7: A flipped bit in any check word is repaired by rewriting that check word. This holds for a Hamming check word (syndrome a power of two) and for the parity word (zero syndrome, failed parity). Each counts as one correction.
- R8: When a slice shows a nonzero syndrome with even overall parity, the scrub writes nothing to it and adds one to the uncorrectable counter. It also reports that slice's block index and bit position on err_block and err_slice.
- R9: busy goes high on the clock after an accepted start. A start pulse while busy is ignored, and busy stays low once the operation is done. If both starts arrive together, encode wins. A group count of zero starts nothing.
- R10: Out of reset the engine is idle, both counters read zero, and the RAM port is quiet.
- R11: Every write made by a scrub goes to the address read in the cycle just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_encode | input | 1 | Start building check words (one-cycle pulse) |
| start_scrub | input | 1 | Start a check-and-repair pass (one-cycle pulse) |
| base_addr | input | 16 | First word of the protected region |
| group_count | input | 8 | Number of four-block groups (256 words each) |
| busy | output | 1 | Operation in progress |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, valid one cycle after a read |
| corr_count | output | 16 | Number of repaired bits since reset |
| unc_count | output | 16 | Number of uncorrectable slices since reset |
| err_block | output | 10 | Block index of the latest uncorrectable slice |
| err_slice | output | 5 | Bit position of the latest uncorrectable slice |

## Verification
The assertions watch every cycle for properties that hold regardless of content. Every data row must drive at least two Hamming lanes. Encode writes must stay inside the check area, and each scrub write must be a read-modify-write of the word just read. The counters may step by at most one, and busy may rise only after a start. Whether the check words carry the right values, which address a given error lands on, and whether double errors leave memory untouched depend on the stored content. Only the bench scenarios show these: single flips, two flips in one word, flips in neighbouring words, check-word and parity-word flips, and a same-slice double.

// File: rtl/vsc_pkg.sv
`timescale 1ns/1ps
// Shared types and position arithmetic for the vertical SEC-DED scrubber.
// Assumes Hamming positions start at 1, with check bits at powers of two.
package vsc_pkg;

    typedef enum logic [1:0] {
        SL_CLEAN    = 2'd0,
        SL_FIX_DATA = 2'd1,
        SL_FIX_CHK  = 2'd2,
        SL_DOUBLE   = 2'd3
    } slice_class_e;

    // Hamming position of a data row: skip every power of two on the way up.
    function automatic int ham_pos(input int row, input int nham);
        int p;
        p = row + 3;
        for (int k = 2; k < nham; k++) begin
            if (p >= (1 << k)) p = p + 1;
        end
        return p;
    endfunction

    // Index of the highest set bit of a positive value.
    function automatic int top_bit(input int v);
        int m;
        m = 0;
        for (int k = 0; k < 31; k++) begin
            if (v >= (1 << k)) m = k;
        end
        return m;
    endfunction

endpackage

// File: rtl/vsc_accum.sv
`timescale 1ns/1ps
// Syndrome / check accumulators for all slices of one block.
// Every word read is XORed into the Hamming lanes chosen by its position,
// and always into the overall-parity lane. Indices below NROW are data rows;
// indices NROW..NROW+NHAM are check words 0..NHAM (parity word last).
module vsc_accum
    import vsc_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NROW  = 64,
    parameter int NHAM  = 7,
    parameter int IDX_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     upd,
    input  logic [IDX_W-1:0]         idx,
    input  logic [DW-1:0]            word,
    output logic [NHAM-1:0][DW-1:0]  ham_o,
    output logic [DW-1:0]            par_o
);

    logic [NHAM-1:0]           sel;
    logic [NHAM-1:0][DW-1:0]   ham_q;
    logic [DW-1:0]             par_q;

    // Pick the Hamming lanes that the incoming word contributes to.
    always_comb begin
        int j;
        sel = '0;
        j   = int'(idx) - NROW;
        if (int'(idx) < NROW)
            sel = NHAM'(ham_pos(int'(idx), NHAM));
        else if (j < NHAM)
            sel = NHAM'(1) << j;
    end

    // Fold the word into the selected lanes and the parity lane.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ham_q <= '0;
            par_q <= '0;
        end else if (upd) begin
            for (int j = 0; j < NHAM; j++) begin
                if (sel[j]) ham_q[j] <= ham_q[j] ^ word;
            end
            par_q <= par_q ^ word;
        end
    end

    assign ham_o = ham_q;
    assign par_o = par_q;

    // A data row never sits at a power-of-two position.
    assert_data_row_two_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && int'(idx) < NROW) |-> ($countones(sel) >= 2));

endmodule

// File: rtl/vsc_slice_dec.sv
`timescale 1ns/1ps
// Per-slice classifier: turns the accumulated syndrome and parity of each
// slice into clean / repair-data / repair-check / uncorrectable, plus a
// target (data row, or check word index with NHAM meaning the parity word).
// Assumes NROW > NHAM so the target width also covers check indices.
module vsc_slice_dec
    import vsc_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NROW  = 64,
    parameter int NHAM  = 7,
    parameter int TGT_W = 6
) (
    input  logic [NHAM-1:0][DW-1:0]  ham_i,
    input  logic [DW-1:0]            par_i,
    output logic [DW-1:0][1:0]       cls_o,
    output logic [DW-1:0][TGT_W-1:0] tgt_o
);

    for (genvar g = 0; g < DW; g++) begin : g_slice
        logic [NHAM-1:0] syn;
        slice_class_e    cls_l;
        logic [TGT_W-1:0] tgt_l;

        // Gather this slice's syndrome from the lanes.
        always_comb begin
            for (int j = 0; j < NHAM; j++) syn[j] = ham_i[j][g];
        end

        // Classify the slice and name the bit to flip.
        always_comb begin
            int msb;
            int row;
            msb   = top_bit(int'(syn));
            row   = int'(syn) - msb - 2;
            cls_l = SL_CLEAN;
            tgt_l = '0;
            if (syn == '0) begin
                if (par_i[g]) begin
                    cls_l = SL_FIX_CHK;
                    tgt_l = TGT_W'(NHAM);
                end
            end else if (!par_i[g]) begin
                cls_l = SL_DOUBLE;
            end else if ($onehot(syn)) begin
                cls_l = SL_FIX_CHK;
                tgt_l = TGT_W'(msb);
            end else if (row < NROW) begin
                cls_l = SL_FIX_DATA;
                tgt_l = TGT_W'(row);
            end else begin
                cls_l = SL_DOUBLE;
            end
        end

        assign cls_o[g] = cls_l;
        assign tgt_o[g] = tgt_l;
    end

endmodule

// File: rtl/vsc_seq.sv
`timescale 1ns/1ps
// Sequencer: walks blocks, issues RAM reads for the accumulators, writes
// check words on encode, and on scrub scans slices one per cycle, repairing
// by read-modify-write. Assumes a RAM with one-cycle read latency and NWAY a
// power of two. Owns the event counters and the uncorrectable report.
module vsc_seq
    import vsc_pkg::*;
#(
    parameter int DW     = 32,
    parameter int NROW   = 64,
    parameter int NHAM   = 7,
    parameter int NWAY   = 4,
    parameter int ADDR_W = 16,
    parameter int GRP_W  = 8,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 7,
    parameter int TGT_W  = 6,
    parameter int BLK_W  = 10,
    parameter int SL_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_encode,
    input  logic                     start_scrub,
    input  logic [ADDR_W-1:0]        base_addr,
    input  logic [GRP_W-1:0]         group_count,
    output logic                     busy,
    output logic                     mem_en,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DW-1:0]            mem_wdata,
    input  logic [DW-1:0]            mem_rdata,
    output logic                     acc_clr,
    output logic                     acc_upd,
    output logic [IDX_W-1:0]         acc_idx,
    input  logic [NHAM-1:0][DW-1:0]  ham_i,
    input  logic [DW-1:0]            par_i,
    input  logic [DW-1:0][1:0]       cls_i,
    input  logic [DW-1:0][TGT_W-1:0] tgt_i,
    output logic [CNT_W-1:0]         corr_count,
    output logic [CNT_W-1:0]         unc_count,
    output logic [BLK_W-1:0]         err_block,
    output logic [SL_W-1:0]          err_slice
);

    localparam int NCHK      = NHAM + 1;
    localparam int WAY_W     = $clog2(NWAY);
    localparam int CJ_W      = $clog2(NCHK);
    localparam int GRP_WORDS = NWAY * NROW;

    typedef enum logic [2:0] {
        S_IDLE, S_READ, S_DRAIN, S_ENC_WR, S_SCAN, S_FIX_RD, S_FIX_WR, S_NEXT
    } state_e;

    state_e            state;
    logic              is_scrub;
    logic [ADDR_W-1:0] base_q;
    logic [GRP_W-1:0]  groups_q;
    logic [BLK_W-1:0]  blk;
    logic [IDX_W-1:0]  idx;
    logic [SL_W-1:0]   sl;
    logic [CJ_W-1:0]   chk_j;
    logic [ADDR_W-1:0] fix_addr_q;
    logic              rv_q;
    logic [IDX_W-1:0]  ridx_q;

    logic              go;
    logic [IDX_W-1:0]  last_idx;
    logic [BLK_W-1:0]  last_blk;
    logic              last_sl;
    logic [ADDR_W-1:0] chk_base, blk_data_base, blk_chk_base, rd_addr, fix_tgt_addr;
    logic [DW-1:0]     enc_word;
    slice_class_e      cur_cls;
    logic [TGT_W-1:0]  cur_tgt;

    assign go       = (start_encode || start_scrub) && (group_count != '0);
    assign last_idx = is_scrub ? IDX_W'(NROW + NCHK - 1) : IDX_W'(NROW - 1);
    assign last_blk = BLK_W'({groups_q, {WAY_W{1'b0}}}) - BLK_W'(1);
    assign last_sl  = (sl == SL_W'(DW - 1));
    assign busy     = (state != S_IDLE);
    assign cur_cls  = slice_class_e'(cls_i[sl]);
    assign cur_tgt  = tgt_i[sl];

    // Interleaved address map: rows stride by NWAY, check area after region.
    assign chk_base      = base_q + ADDR_W'(groups_q) * ADDR_W'(GRP_WORDS);
    assign blk_data_base = base_q + ADDR_W'(blk >> WAY_W) * ADDR_W'(GRP_WORDS)
                         + ADDR_W'(blk[WAY_W-1:0]);
    assign blk_chk_base  = chk_base + ADDR_W'(blk) * ADDR_W'(NCHK);

    // Address of the word being read in the accumulation pass.
    always_comb begin
        if (int'(idx) < NROW)
            rd_addr = blk_data_base + ADDR_W'(idx) * ADDR_W'(NWAY);
        else
            rd_addr = blk_chk_base + ADDR_W'(int'(idx) - NROW);
    end

    // Address of the word holding the bit that a repair must flip.
    always_comb begin
        if (cur_cls == SL_FIX_DATA)
            fix_tgt_addr = blk_data_base + ADDR_W'(cur_tgt) * ADDR_W'(NWAY);
        else
            fix_tgt_addr = blk_chk_base + ADDR_W'(cur_tgt);
    end

    // Check word to write on encode; the last one folds in overall parity.
    always_comb begin
        logic [DW-1:0] fold;
        fold     = par_i;
        enc_word = '0;
        for (int j = 0; j < NHAM; j++) begin
            fold = fold ^ ham_i[j];
            if (CJ_W'(j) == chk_j) enc_word = ham_i[j];
        end
        if (chk_j == CJ_W'(NHAM)) enc_word = fold;
    end

    // RAM port drive, decoded from the state.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            S_READ: begin
                mem_en   = 1'b1;
                mem_addr = rd_addr;
            end
            S_ENC_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = blk_chk_base + ADDR_W'(chk_j);
                mem_wdata = enc_word;
            end
            S_FIX_RD: begin
                mem_en   = 1'b1;
                mem_addr = fix_addr_q;
            end
            S_FIX_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = fix_addr_q;
                mem_wdata = mem_rdata ^ (DW'(1) << sl);
            end
            default: ;
        endcase
    end

    // Accumulator control: clear per block, fold one returned word per cycle.
    assign acc_clr = (state == S_NEXT) || (state == S_IDLE && go);
    assign acc_upd = rv_q;
    assign acc_idx = ridx_q;

    // Main sequencing, counters and uncorrectable report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            is_scrub   <= 1'b0;
            base_q     <= '0;
            groups_q   <= '0;
            blk        <= '0;
            idx        <= '0;
            sl         <= '0;
            chk_j      <= '0;
            fix_addr_q <= '0;
            rv_q       <= 1'b0;
            ridx_q     <= '0;
            corr_count <= '0;
            unc_count  <= '0;
            err_block  <= '0;
            err_slice  <= '0;
        end else begin
            rv_q   <= (state == S_READ);
            ridx_q <= idx;
            case (state)
                S_IDLE: begin
                    if (go) begin
                        base_q   <= base_addr;
                        groups_q <= group_count;
                        is_scrub <= !start_encode;
                        blk      <= '0;
                        idx      <= '0;
                        state    <= S_READ;
                    end
                end
                S_READ: begin
                    idx <= idx + IDX_W'(1);
                    if (idx == last_idx) state <= S_DRAIN;
                end
                S_DRAIN: begin
                    sl    <= '0;
                    chk_j <= '0;
                    state <= is_scrub ? S_SCAN : S_ENC_WR;
                end
                S_ENC_WR: begin
                    chk_j <= chk_j + CJ_W'(1);
                    if (chk_j == CJ_W'(NCHK - 1)) state <= S_NEXT;
                end
                S_SCAN: begin
                    if (cur_cls == SL_FIX_DATA || cur_cls == SL_FIX_CHK) begin
                        fix_addr_q <= fix_tgt_addr;
                        state      <= S_FIX_RD;
                    end else begin
                        if (cur_cls == SL_DOUBLE) begin
                            unc_count <= unc_count + CNT_W'(1);
                            err_block <= blk;
                            err_slice <= sl;
                        end
                        if (last_sl) state <= S_NEXT;
                        else         sl    <= sl + SL_W'(1);
                    end
                end
                S_FIX_RD: state <= S_FIX_WR;
                S_FIX_WR: begin
                    corr_count <= corr_count + CNT_W'(1);
                    if (last_sl) state <= S_NEXT;
                    else begin
                        sl    <= sl + SL_W'(1);
                        state <= S_SCAN;
                    end
                end
                S_NEXT: begin
                    if (blk == last_blk) state <= S_IDLE;
                    else begin
                        blk   <= blk + BLK_W'(1);
                        idx   <= '0;
                        state <= S_READ;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_enc_writes_check_area_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !is_scrub) |-> (mem_addr >= chk_base));

    assert_scrub_write_is_rmw_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && is_scrub) |-> ($past(mem_en) && !$past(mem_we) && mem_addr == $past(mem_addr)));

    assert_corr_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (corr_count == $past(corr_count) || corr_count == $past(corr_count) + CNT_W'(1)));

    assert_unc_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (unc_count == $past(unc_count) || unc_count == $past(unc_count) + CNT_W'(1)));

    assert_busy_follows_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_encode || start_scrub));

endmodule

// File: rtl/vslice_scrubber.sv
`timescale 1ns/1ps
// Vertical SEC-DED scrubber top: a codeword is one bit slice across NROW
// words of a block; NWAY blocks are interleaved per group. Assumes a
// single-port synchronous RAM with one-cycle read latency owned by the engine
// while busy.
module vslice_scrubber
    import vsc_pkg::*;
#(
    parameter int DW     = 32,
    parameter int NROW   = 64,
    parameter int NHAM   = 7,
    parameter int NWAY   = 4,
    parameter int ADDR_W = 16,
    parameter int GRP_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_encode,
    input  logic                          start_scrub,
    input  logic [ADDR_W-1:0]             base_addr,
    input  logic [GRP_W-1:0]              group_count,
    output logic                          busy,
    output logic                          mem_en,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [DW-1:0]                 mem_wdata,
    input  logic [DW-1:0]                 mem_rdata,
    output logic [CNT_W-1:0]              corr_count,
    output logic [CNT_W-1:0]              unc_count,
    output logic [GRP_W+$clog2(NWAY)-1:0] err_block,
    output logic [$clog2(DW)-1:0]         err_slice
);

    localparam int NCHK  = NHAM + 1;
    localparam int IDX_W = $clog2(NROW + NCHK);
    localparam int TGT_W = $clog2(NROW);
    localparam int BLK_W = GRP_W + $clog2(NWAY);
    localparam int SL_W  = $clog2(DW);

    logic                     acc_clr, acc_upd;
    logic [IDX_W-1:0]         acc_idx;
    logic [NHAM-1:0][DW-1:0]  ham;
    logic [DW-1:0]            par;
    logic [DW-1:0][1:0]       cls;
    logic [DW-1:0][TGT_W-1:0] tgt;

    vsc_accum #(.DW(DW), .NROW(NROW), .NHAM(NHAM), .IDX_W(IDX_W)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .upd   (acc_upd),
        .idx   (acc_idx),
        .word  (mem_rdata),
        .ham_o (ham),
        .par_o (par)
    );

    vsc_slice_dec #(.DW(DW), .NROW(NROW), .NHAM(NHAM), .TGT_W(TGT_W)) u_dec (
        .ham_i (ham),
        .par_i (par),
        .cls_o (cls),
        .tgt_o (tgt)
    );

    vsc_seq #(
        .DW(DW), .NROW(NROW), .NHAM(NHAM), .NWAY(NWAY), .ADDR_W(ADDR_W),
        .GRP_W(GRP_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .TGT_W(TGT_W),
        .BLK_W(BLK_W), .SL_W(SL_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_encode (start_encode),
        .start_scrub  (start_scrub),
        .base_addr    (base_addr),
        .group_count  (group_count),
        .busy         (busy),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .acc_clr      (acc_clr),
        .acc_upd      (acc_upd),
        .acc_idx      (acc_idx),
        .ham_i        (ham),
        .par_i        (par),
        .cls_i        (cls),
        .tgt_i        (tgt),
        .corr_count   (corr_count),
        .unc_count    (unc_count),
        .err_block    (err_block),
        .err_slice    (err_slice)
    );

endmodule

// File: tb/sim_vslice_scrubber.sv
`timescale 1ns/1ps
module sim_vslice_scrubber;
    localparam int NROW = 64, NCHK = 8, NWAY = 4;
    localparam int BASE = 16, GROUPS = 1;
    localparam int CHK0 = BASE + GROUPS * NWAY * NROW;
    localparam int LAST = CHK0 + GROUPS * NWAY * NCHK;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        start_encode = 1'b0, start_scrub = 1'b0;
    logic [15:0] base_addr = 16'(BASE);
    logic [7:0]  group_count = 8'(GROUPS);
    logic        busy, mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [15:0] corr_count, unc_count;
    logic [9:0]  err_block;
    logic [4:0]  err_slice;

    logic [31:0] mem [0:511];
    logic [31:0] gm  [0:511];
    int posr [NROW];
    int errors = 0, checks = 0, cyc = 0;
    bit op_scrub = 1'b0, prev_rd = 1'b0;
    logic [15:0] prev_addr = '0;

    always #2.5 clk = ~clk;

    vslice_scrubber u0 (.*);

    // Behavioural RAM, one-cycle read latency.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[8:0]];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle model of legal writes: encode stays in check area, scrub is RMW.
    always @(negedge clk) begin
        if (rst_n && mem_en && mem_we) begin
            if (!op_scrub)
                check(int'(mem_addr) >= CHK0 && int'(mem_addr) < LAST, "R2",
                      "encode write address", mem_addr, CHK0);
            else
                check(prev_rd && prev_addr == mem_addr, "R11",
                      "scrub write follows read", mem_addr, prev_addr);
        end
        prev_rd   <= rst_n && mem_en && !mem_we;
        prev_addr <= mem_addr;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int daddr(int b, int r);
        return BASE + (b / NWAY) * NWAY * NROW + r * NWAY + (b % NWAY);
    endfunction
    function automatic int caddr(int b, int j);
        return CHK0 + b * NCHK + j;
    endfunction

    // Reference encoder from the position definition.
    task automatic build_golden();
        for (int b = 0; b < GROUPS * NWAY; b++) begin
            logic [31:0] c [NCHK];
            for (int j = 0; j < NCHK; j++) c[j] = '0;
            for (int r = 0; r < NROW; r++) begin
                for (int j = 0; j < NCHK - 1; j++)
                    if ((posr[r] >> j) & 1) c[j] ^= gm[daddr(b, r)];
                c[NCHK-1] ^= gm[daddr(b, r)];
            end
            for (int j = 0; j < NCHK - 1; j++) c[NCHK-1] ^= c[j];
            for (int j = 0; j < NCHK; j++) gm[caddr(b, j)] = c[j];
        end
    endtask

    task automatic cmp_mem(input string req);
        int mm = 0, first = -1;
        for (int a = BASE; a < LAST; a++)
            if (mem[a] !== gm[a]) begin mm++; if (first < 0) first = a; end
        check(mm == 0, req, $sformatf("memory mismatches (first at %0d)", first), mm, 0);
    endtask

    task automatic run_op(input bit scrub, input string req);
        op_scrub = scrub;
        @(negedge clk);
        if (scrub) start_scrub = 1'b1; else start_encode = 1'b1;
        @(negedge clk);
        start_scrub = 1'b0; start_encode = 1'b0;
        check(busy == 1'b1, req, "busy after start", busy, 1);
        while (busy) @(negedge clk);
    endtask

    initial begin
        int p, r;
        logic [31:0] x;
        bit stayed_low;
        p = 1; r = 0;
        while (r < NROW) begin
            if ((p & (p - 1)) != 0) begin posr[r] = p; r++; end
            p++;
        end
        x = 32'h1234_5678;
        for (int a = 0; a < 512; a++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            mem[a] = (a >= BASE && a < CHK0) ? x : 32'h0;
            gm[a]  = mem[a];
        end
        build_golden();

        // R10: reset state
        repeat (4) @(negedge clk);
        check(busy == 0 && mem_en == 0, "R10", "idle port in reset", {busy, mem_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && mem_en == 0, "R10", "idle port after reset", {busy, mem_en}, 0);
        check(corr_count == 0 && unc_count == 0, "R10", "counters after reset",
              {corr_count, unc_count}, 0);

        // R9: zero group count starts nothing
        group_count = 8'd0;
        start_scrub = 1'b1; @(negedge clk); start_scrub = 1'b0; @(negedge clk);
        check(busy == 0, "R9", "zero groups ignored", busy, 0);
        group_count = 8'(GROUPS);

        // R1/R2/R9: encode with a stray scrub start in the middle
        op_scrub = 1'b0;
        start_encode = 1'b1; @(negedge clk); start_encode = 1'b0;
        check(busy == 1, "R9", "busy after encode start", busy, 1);
        repeat (10) @(negedge clk);
        start_scrub = 1'b1; @(negedge clk); start_scrub = 1'b0;
        while (busy) @(negedge clk);
        stayed_low = 1'b1;
        repeat (4) begin @(negedge clk); if (busy) stayed_low = 1'b0; end
        check(stayed_low, "R9", "start while busy ignored", !stayed_low, 0);
        cmp_mem("R1");
        check(mem[caddr(2, 7)] === gm[caddr(2, 7)], "R1", "parity word block 2",
              mem[caddr(2, 7)], gm[caddr(2, 7)]);

        // R4: clean scrub
        run_op(1'b1, "R9");
        cmp_mem("R4");
        check(corr_count == 0 && unc_count == 0, "R4", "counters after clean scrub",
              {corr_count, unc_count}, 0);

        // R5/R3: single data flip at block 2 row 5 bit 7
        mem[daddr(2, 5)] ^= 32'h80;
        run_op(1'b1, "R9");
        check(mem[daddr(2, 5)] === gm[daddr(2, 5)], "R3", "interleaved word repaired",
              mem[daddr(2, 5)], gm[daddr(2, 5)]);
        cmp_mem("R5");
        check(corr_count == 1, "R5", "corrected count", corr_count, 1);

        // R6: two bits in one word, plus adjacent words in different blocks
        mem[daddr(1, 63)] ^= 32'h8000_0001;
        mem[BASE + 40] ^= 32'h8;
        mem[BASE + 41] ^= 32'h8;
        run_op(1'b1, "R9");
        cmp_mem("R6");
        check(corr_count == 5, "R6", "corrected count", corr_count, 5);

        // R7: Hamming check word and parity word flips
        mem[caddr(3, 2)] ^= 32'h200;
        mem[caddr(0, 7)] ^= 32'h10;
        run_op(1'b1, "R9");
        cmp_mem("R7");
        check(corr_count == 7, "R7", "corrected count", corr_count, 7);

        // R8: two flips in one slice of block 3 (rows 0 and 1, bit 12)
        mem[daddr(3, 0)] ^= 32'h1000;
        mem[daddr(3, 1)] ^= 32'h1000;
        run_op(1'b1, "R9");
        gm[daddr(3, 0)] ^= 32'h1000;
        gm[daddr(3, 1)] ^= 32'h1000;
        cmp_mem("R8");
        gm[daddr(3, 0)] ^= 32'h1000;
        gm[daddr(3, 1)] ^= 32'h1000;
        check(unc_count == 1, "R8", "uncorrectable count", unc_count, 1);
        check(err_block == 3, "R8", "reported block", err_block, 3);
        check(err_slice == 12, "R8", "reported slice", err_slice, 12);
        check(corr_count == 7, "R8", "no correction on double", corr_count, 7);

        mem[daddr(3, 0)] ^= 32'h1000;
        mem[daddr(3, 1)] ^= 32'h1000;
        run_op(1'b1, "R9");
        cmp_mem("R4");
        check(corr_count == 7 && unc_count == 1, "R4", "counters after restore",
              {corr_count, unc_count}, {16'd7, 16'd1});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule